// File: doc/BRIEF.md
# CAN Bus-Off Recovery Sequencer

This block controls how a CAN controller comes back from the bus-off state. When the error-counter logic signals bus-off entry, the sequencer sets the controller's init bit by itself, which halts all bus activity. It then waits for software to clear that bit. Only after that does it start watching the sampled bus bits, which arrive with a bit-strobe.

During recovery the block counts runs of eleven consecutive recessive bits. Each completed run is one bus-idle detection. For each one, the block pulses a request to write the bit0 error code into the status register, and it advances a sequence count that is visible on the receive-error-count path. After the 129th detection it pulses a reset of the error management counters and a done pulse, and it returns to idle. Software writes to the init bit during recovery cannot shorten the sequence.

Top module: `busoff_recovery_seq`

## Requirements
- R1: After reset, initBit is 0, recoverCount is 0 and bit0ErrReq, errCntReset and recoverDone are all low.
- R2: In the idle state, a busOffEnter pulse sets initBit on the next clock and starts a bus-off hold. The pulse takes priority over a CPU init write in the same cycle.
- R3: During the hold, initBit stays 1 until the CPU writes initWrData=0, and bit-strobes are not counted: recoverCount stays 0 and bit0ErrReq stays low. A CPU write of 1 keeps the hold.
- R4: Once the CPU has cleared initBit, the 11th consecutive recessive strobe (busBit=1) has two effects in the cycle after the edge that samples it: bit0ErrReq is high for exactly one cycle, and recoverCount rises by one. Cycles without bitStrobe count nothing.
- R5: A dominant strobe (busBit=0) during counting restarts the run of recessive bits and leaves recoverCount unchanged.
- R6: The recessive run restarts from zero after each completed 11-bit sequence, so recessive bits after a completed run count toward the next one.
- R7: When the 129th sequence completes, bit0ErrReq, errCntReset and recoverDone are high together for one cycle. recoverCount returns to 0, and the block is idle again, so a later busOffEnter starts a new recovery.
- R8: CPU init writes during counting change initBit only. They neither reset nor advance the count, and recovery still takes exactly 129 × 11 recessive strobes.
- R9: busOffEnter during hold or counting is ignored: recoverCount and the run in progress are kept.
- R10: In the idle state, CPU writes set and clear initBit directly, and strobes produce no pulses and no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitStrobe | input | 1 | Marks a cycle that carries a sampled bus bit |
| busBit | input | 1 | Sampled bus level, 1 = recessive, 0 = dominant |
| busOffEnter | input | 1 | Bus-off entry pulse from error-counter logic |
| initWrEn | input | 1 | CPU write strobe for the init bit |
| initWrData | input | 1 | Value written to the init bit |
| initBit | output | 1 | Init control bit, 1 halts bus activity |
| recoverCount | output | SEQ_W (8) | Completed 11-bit idle sequences in this recovery |
| bit0ErrReq | output | 1 | One-cycle request to write the bit0 error code |
| errCntReset | output | 1 | One-cycle reset of the error management counters |
| recoverDone | output | 1 | One-cycle end-of-recovery marker |

## Verification
A wrong sequencer state shows up at the ports within one cycle of the next relevant input. A lost hold lets recoverCount move before the CPU clears init. A stale run counter moves the bit0ErrReq pulse earlier or later than the 11th recessive strobe. A mishandled completion puts errCntReset and recoverDone on the wrong strobe of the 1419-strobe window. The bench models the expected values for every cycle and compares all outputs after each clock. This exposes an off-by-one in either counter at the first pulse that lands in the wrong cycle.

// File: rtl/busoff_pkg.sv
package busoff_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_COUNT = 2'd2
  } recState_t;

  typedef struct packed {
    logic clearAll;
    logic runClear;
    logic runAdvance;
    logic finish;
  } dpStrobe_t;
endpackage

// File: rtl/busoff_ctrl.sv
module busoff_ctrl
  import busoff_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitStrobe,
  input  logic      busBit,
  input  logic      busOffEnter,
  input  logic      initWrEn,
  input  logic      initWrData,
  input  logic      runAtLast,
  input  logic      seqAtLast,
  output dpStrobe_t strobes,
  output logic      initBit
);
  recState_t state, nextState;
  logic      nextInit;

  always_comb begin
    strobes   = '0;
    nextState = state;
    nextInit  = initBit;
    case (state)
      ST_IDLE: begin
        if (busOffEnter) begin
          nextInit         = 1'b1;
          nextState        = ST_HOLD;
          strobes.clearAll = 1'b1;
        end else if (initWrEn) begin
          nextInit = initWrData;
        end
      end
      ST_HOLD: begin
        if (initWrEn) begin
          nextInit = initWrData;
          if (!initWrData) nextState = ST_COUNT;
        end
      end
      ST_COUNT: begin
        if (initWrEn) nextInit = initWrData;
        if (bitStrobe) begin
          if (!busBit) begin
            strobes.runClear = 1'b1;
          end else begin
            strobes.runAdvance = 1'b1;
            if (runAtLast && seqAtLast) begin
              strobes.finish = 1'b1;
              nextState      = ST_IDLE;
            end
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      initBit <= 1'b0;
    end else begin
      state   <= nextState;
      initBit <= nextInit;
    end
  end

  assert_enter_sets_init_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && busOffEnter) |=> (initBit && state == ST_HOLD));

  assert_hold_keeps_init_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD) |-> initBit);

  assert_finish_to_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.finish |=> (state == ST_IDLE));

  assert_offenter_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_COUNT && busOffEnter && !strobes.finish) |=> (state == ST_COUNT));
endmodule

// File: rtl/busoff_dp.sv
module busoff_dp
  import busoff_pkg::*;
#(
  parameter int RUN_LEN   = 11,
  parameter int SEQ_COUNT = 129,
  localparam int RUN_W    = $clog2(RUN_LEN + 1),
  localparam int SEQ_W    = $clog2(SEQ_COUNT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobes,
  output logic             runAtLast,
  output logic             seqAtLast,
  output logic [SEQ_W-1:0] seqCount,
  output logic             bit0Pulse,
  output logic             rstPulse,
  output logic             donePulse
);
  logic [RUN_W-1:0] runCount;

  assign runAtLast = (runCount == RUN_W'(RUN_LEN - 1));
  assign seqAtLast = (seqCount == SEQ_W'(SEQ_COUNT - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCount  <= '0;
      seqCount  <= '0;
      bit0Pulse <= 1'b0;
      rstPulse  <= 1'b0;
      donePulse <= 1'b0;
    end else begin
      bit0Pulse <= 1'b0;
      rstPulse  <= 1'b0;
      donePulse <= 1'b0;
      if (strobes.clearAll) begin
        runCount <= '0;
        seqCount <= '0;
      end else if (strobes.runClear) begin
        runCount <= '0;
      end else if (strobes.runAdvance) begin
        if (runAtLast) begin
          runCount  <= '0;
          bit0Pulse <= 1'b1;
          if (strobes.finish) begin
            seqCount  <= '0;
            rstPulse  <= 1'b1;
            donePulse <= 1'b1;
          end else begin
            seqCount <= seqCount + 1'b1;
          end
        end else begin
          runCount <= runCount + 1'b1;
        end
      end
    end
  end

  assert_run_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    runCount < RUN_W'(RUN_LEN));

  assert_dominant_keeps_seq_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.runClear |=> (runCount == '0 && seqCount == $past(seqCount)));

  assert_seq_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (seqCount != $past(seqCount)) |-> (seqCount == $past(seqCount) + 1'b1 || seqCount == '0));

  assert_done_together_R7: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (rstPulse && bit0Pulse && seqCount == '0));
endmodule

// File: rtl/busoff_recovery_seq.sv
module busoff_recovery_seq
  import busoff_pkg::*;
#(
  parameter int RUN_LEN   = 11,
  parameter int SEQ_COUNT = 129,
  localparam int SEQ_W    = $clog2(SEQ_COUNT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitStrobe,
  input  logic             busBit,
  input  logic             busOffEnter,
  input  logic             initWrEn,
  input  logic             initWrData,
  output logic             initBit,
  output logic [SEQ_W-1:0] recoverCount,
  output logic             bit0ErrReq,
  output logic             errCntReset,
  output logic             recoverDone
);
  dpStrobe_t strobes;
  logic      runAtLast;
  logic      seqAtLast;

  busoff_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .bitStrobe  (bitStrobe),
    .busBit     (busBit),
    .busOffEnter(busOffEnter),
    .initWrEn   (initWrEn),
    .initWrData (initWrData),
    .runAtLast  (runAtLast),
    .seqAtLast  (seqAtLast),
    .strobes    (strobes),
    .initBit    (initBit)
  );

  busoff_dp #(
    .RUN_LEN  (RUN_LEN),
    .SEQ_COUNT(SEQ_COUNT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .runAtLast(runAtLast),
    .seqAtLast(seqAtLast),
    .seqCount (recoverCount),
    .bit0Pulse(bit0ErrReq),
    .rstPulse (errCntReset),
    .donePulse(recoverDone)
  );
endmodule

// File: tb/busoff_recovery_seq_tb.sv
module busoff_recovery_seq_tb;
  localparam int RUN_LEN   = 11;
  localparam int SEQ_COUNT = 129;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitStrobe = 1'b0, busBit = 1'b1, busOffEnter = 1'b0;
  logic       initWrEn = 1'b0, initWrData = 1'b0;
  logic       initBit, bit0ErrReq, errCntReset, recoverDone;
  logic [7:0] recoverCount;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  int mMode = 0, mRun = 0, mSeq = 0;
  logic mInit = 0, eBit0 = 0, eDone = 0;

  always #10 clk = ~clk;

  busoff_recovery_seq u_dut (
    .clk(clk), .rstN(rstN), .bitStrobe(bitStrobe), .busBit(busBit),
    .busOffEnter(busOffEnter), .initWrEn(initWrEn), .initWrData(initWrData),
    .initBit(initBit), .recoverCount(recoverCount), .bit0ErrReq(bit0ErrReq),
    .errCntReset(errCntReset), .recoverDone(recoverDone)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int nextRun(input int run, input logic b);
    if (!b) return 0;
    return (run == RUN_LEN - 1) ? 0 : run + 1;
  endfunction

  task automatic modelUpdate(input logic s, b, off, we, wd);
    eBit0 = 0; eDone = 0;
    case (mMode)
      0: if (off) begin mInit = 1; mMode = 1; mSeq = 0; mRun = 0; end
         else if (we) mInit = wd;
      1: if (we) begin mInit = wd; if (!wd) mMode = 2; end
      default: begin
        if (we) mInit = wd;
        if (s) begin
          if (b && mRun == RUN_LEN - 1) begin
            eBit0 = 1;
            if (mSeq == SEQ_COUNT - 1) begin mSeq = 0; eDone = 1; mMode = 0; end
            else mSeq++;
          end
          mRun = nextRun(mRun, b);
        end
      end
    endcase
  endtask

  task automatic step(input logic s, b, off, we, wd, input string tag);
    @(negedge clk);
    bitStrobe = s; busBit = b; busOffEnter = off; initWrEn = we; initWrData = wd;
    @(posedge clk);
    modelUpdate(s, b, off, we, wd);
    #5;
    bitStrobe = 0; busOffEnter = 0; initWrEn = 0;
    chk(tag, "initBit", initBit, mInit);
    chk(tag, "recoverCount", recoverCount, mSeq);
    chk(tag, "bit0ErrReq", bit0ErrReq, eBit0);
    chk(tag, "errCntReset", errCntReset, eDone);
    chk(tag, "recoverDone", recoverDone, eDone);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int strobeCnt;
    int pulses;
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(posedge clk);
    #5;
    chk("R1", "initBit", initBit, 0);
    chk("R1", "recoverCount", recoverCount, 0);
    chk("R1", "pulses", {bit0ErrReq, errCntReset, recoverDone}, 0);
    @(negedge clk); rstN = 1;

    // R10: idle writes and strobes
    step(0, 1, 0, 1, 1, "R10");
    step(0, 1, 0, 1, 0, "R10");
    for (int i = 0; i < 25; i++) step(1, 1, 0, 0, 0, "R10");

    // R2: bus-off entry beats a simultaneous clear write
    step(0, 1, 1, 1, 0, "R2");
    chk("R2", "initBit set", initBit, 1);

    // R3: hold ignores strobes; writing 1 keeps the hold
    for (int i = 0; i < 30; i++) step(1, 1, 0, 0, 0, "R3");
    step(0, 1, 0, 1, 1, "R3");
    for (int i = 0; i < 12; i++) step(1, 1, 0, 0, 0, "R3");
    chk("R3", "count held", recoverCount, 0);
    step(0, 1, 0, 1, 0, "R3");

    // R5/R4: dominant restarts the run
    for (int i = 0; i < 10; i++) step(1, 1, 0, 0, 0, "R5");
    step(1, 0, 0, 0, 0, "R5");
    step(0, 1, 0, 0, 0, "R4");
    for (int i = 0; i < 11; i++) step(1, 1, 0, 0, 0, "R4");
    chk("R4", "first sequence", recoverCount, 1);

    // R6: run restarts after a completed sequence
    for (int i = 0; i < 15; i++) step(1, 1, 0, 0, 0, "R6");
    chk("R6", "second sequence", recoverCount, 2);

    // R9: re-entry ignored; R8: init writes while counting
    step(1, 1, 1, 0, 0, "R9");
    step(1, 1, 0, 1, 1, "R8");
    step(1, 1, 0, 1, 0, "R8");
    chk("R9", "count kept", recoverCount, 2);

    // R7/R8: random traffic until done
    while (mMode == 2) begin
      if ($urandom % 5 == 0) step(0, 1, 0, 0, 0, "R4");
      step(1, ($urandom % 16) != 0, ($urandom % 64) == 0,
           ($urandom % 40) == 0, $urandom % 2, "R7");
    end
    step(1, 1, 0, 0, 0, "R7");

    // R8: exact strobe count, all recessive, with init toggles
    step(0, 1, 1, 0, 0, "R7");
    step(0, 1, 0, 1, 0, "R8");
    strobeCnt = 0; pulses = 0;
    while (mMode == 2 && strobeCnt < 2000) begin
      step(1, 1, 0, (strobeCnt % 97) == 5, strobeCnt[3], "R8");
      strobeCnt++;
      if (bit0ErrReq) pulses++;
    end
    chk("R8", "strobes to finish", strobeCnt, RUN_LEN * SEQ_COUNT);
    chk("R8", "bit0 pulses", pulses, SEQ_COUNT);
    for (int i = 0; i < 12; i++) step(1, 1, 0, 0, 0, "R10");
    finishRun();
  end
endmodule